// File: doc/BRIEF.md
# End-of-Write Status Read Path

This block sits between the storage array of a byte-wide non-volatile memory and its data pins, and decides what a read returns. While no internal write cycle is running, a read returns the array byte at the addressed location. While a write cycle is busy, every read is a status poll. Bit 7 carries the inverse of bit 7 of the last byte written. Bit 6 flips on each new read access. The lower bits read as zero. Software can therefore detect the end of a write in two ways: by waiting for bit 7 to match the written data, or by waiting for bit 6 to stop changing.

The read-active condition is chip select and output enable both low, with the write strobe high. It is sampled on the clock. A small state machine holds one of three states:

- `RD_OFF`: the bus is released.
- `RD_ARRAY`: array data is driven.
- `RD_POLL`: the status word is driven.

Transitions:

- `OFF->ARRAY` or `OFF->POLL` on a new access, depending on busy. Entering `RD_POLL` from `RD_OFF` also advances the toggle flop.
- `ARRAY->POLL` when busy rises during a held read.
- `POLL->ARRAY` when busy falls during a held read.
- Any state to `RD_OFF` when the access ends.

A separate enable output stands in for a high-impedance bus.

Top module: `ewr_status_mux`

## Requirements
- R1: When the read-active condition (cs_n=0, oe_n=0, wr_n=1) was false at the preceding clock edge, dq_oe is 0 and dq_out is all zeros.
- R2: When the read-active condition and busy were both true at the preceding edge, dq_oe is 1 and dq_out[7] equals the inverse of last_wr_byte[7].
- R3: Each new read access that begins while busy is 1 inverts dq_out[6] relative to the previous polled read. A new access is a rising edge of the read-active condition, whether caused by cs_n, by oe_n, or by both.
- R4: When the read-active condition was true and busy was 0 at the preceding edge, dq_oe is 1 and dq_out equals arr_rdata on all eight bits.
- R5: During a status poll (read active and busy at the preceding edge), dq_out[5:0] are all zero.
- R6: The toggle bit keeps its value when no new read access begins, including across idle cycles, across held reads, and from one write cycle to the next. It is not reset at the start of a write cycle.
- R7: A read held continuously across a change of busy switches between array data and status at the next clock edge. When busy rises during such a read, the toggle bit does not advance.
- R8: A low write strobe releases the bus even when cs_n and oe_n are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| busy | input | 1 | Internal write cycle in progress |
| last_wr_byte | input | DATA_W | Last byte loaded by the write path |
| arr_rdata | input | DATA_W | Array read data for the current address |
| dq_out | output | DATA_W | Read data bus value |
| dq_oe | output | 1 | Bus drive enable; 0 means released |

## Verification
Random sequences mix busy and idle periods. In them, reads are begun and ended by chip select alone, by output enable alone, and by both. This separates a toggle that follows access edges from one that follows the clock or a single pin. Directed sequences hold a read across both edges of busy, which tells a mode switch at the next edge apart from a toggle advance. They also hold the strobe low with both enables active, which separates the write-inhibit gating from plain enable decoding. Because the bench predicts alternation only and learns the first polled bit 6, any starting value of the toggle is accepted. A missed or doubled flip is still caught.

// File: rtl/ewr_pkg.sv
package ewr_pkg;
    typedef enum logic [1:0] {
        RD_OFF   = 2'd0,
        RD_ARRAY = 2'd1,
        RD_POLL  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/ewr_rd_qual.sv
// Decodes the read-active condition and flags the cycle in which it rises.
module ewr_rd_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic oe_n,
    input  logic wr_n,
    output logic rd_act,
    output logic rd_rise
);
    logic rd_prev;

    assign rd_act  = !cs_n && !oe_n && wr_n;
    assign rd_rise = rd_act && !rd_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_prev <= 1'b0;
        else        rd_prev <= rd_act;
    end
endmodule

// File: rtl/ewr_toggle_reg.sv
// Flag that flips once per new access made during a write cycle.
module ewr_toggle_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic tgl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    tgl_q <= 1'b0;
        else if (step) tgl_q <= !tgl_q;
    end
endmodule

// File: rtl/ewr_status_fmt.sv
// Builds the status word presented while a write cycle is busy.
module ewr_status_fmt #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] last_wr_byte,
    input  logic              tgl_q,
    output logic [DATA_W-1:0] status_word
);
    localparam int POLL_BIT = DATA_W - 1;
    localparam int TGL_BIT  = DATA_W - 2;

    always_comb begin
        status_word           = '0;
        status_word[POLL_BIT] = !last_wr_byte[POLL_BIT];
        status_word[TGL_BIT]  = tgl_q;
    end
endmodule

// File: rtl/ewr_status_mux.sv
module ewr_status_mux
    import ewr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              wr_n,
    input  logic              busy,
    input  logic [DATA_W-1:0] last_wr_byte,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    rd_state_e         state_q, state_d;
    logic              rd_act, rd_rise, tgl_q, tgl_step;
    logic [DATA_W-1:0] status_word;

    ewr_rd_qual u_qual (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .wr_n(wr_n),
        .rd_act(rd_act), .rd_rise(rd_rise)
    );

    assign tgl_step = rd_rise && busy;

    ewr_toggle_reg u_tgl (
        .clk(clk), .rst_n(rst_n), .step(tgl_step), .tgl_q(tgl_q)
    );

    ewr_status_fmt #(.DATA_W(DATA_W)) u_fmt (
        .last_wr_byte(last_wr_byte), .tgl_q(tgl_q), .status_word(status_word)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_OFF:   if (rd_act) state_d = busy ? RD_POLL : RD_ARRAY;
            RD_ARRAY: if (!rd_act) state_d = RD_OFF;
                      else if (busy) state_d = RD_POLL;
            RD_POLL:  if (!rd_act) state_d = RD_OFF;
                      else if (!busy) state_d = RD_ARRAY;
            default:  state_d = RD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_OFF;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        dq_out = '0;
        dq_oe  = 1'b0;
        unique case (state_q)
            RD_OFF:   begin dq_out = '0;          dq_oe = 1'b0; end
            RD_ARRAY: begin dq_out = arr_rdata;   dq_oe = 1'b1; end
            RD_POLL:  begin dq_out = status_word; dq_oe = 1'b1; end
            default:  begin dq_out = '0;          dq_oe = 1'b0; end
        endcase
    end
endmodule

// File: rtl/ewr_status_chk.sv
module ewr_status_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              oe_n,
    input logic              wr_n,
    input logic              busy,
    input logic [DATA_W-1:0] last_wr_byte,
    input logic [DATA_W-1:0] arr_rdata,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe,
    input logic              rd_rise,
    input logic              tgl_q
);
    logic rd_c;
    assign rd_c = !cs_n && !oe_n && wr_n;

    // R1, R8
    a_r1_released: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_c |=> (!dq_oe && dq_out == '0));
    // R2
    a_r2_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && busy) |=> (dq_oe && dq_out[DATA_W-1] == !last_wr_byte[DATA_W-1]));
    // R3
    a_r3_toggle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rise && busy) |=> (tgl_q != $past(tgl_q)));
    // R4
    a_r4_array_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && !busy) |=> (dq_oe && dq_out == arr_rdata));
    // R5
    a_r5_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && busy) |=> (dq_out[DATA_W-3:0] == '0));
    // R6
    a_r6_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_rise |=> $stable(tgl_q));
endmodule

bind ewr_status_mux ewr_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .wr_n(wr_n),
    .busy(busy), .last_wr_byte(last_wr_byte), .arr_rdata(arr_rdata),
    .dq_out(dq_out), .dq_oe(dq_oe), .rd_rise(rd_rise), .tgl_q(tgl_q)
);

// File: tb/ewr_status_mux_tb.sv
`timescale 1ns/1ps
module ewr_status_mux_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1, oe_n = 1'b1, wr_n = 1'b1, busy = 1'b0;
    logic [W-1:0] last_wr_byte = '0, arr_rdata = '0;
    logic [W-1:0] dq_out;
    logic         dq_oe;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // Bench model state
    bit prev_rd   = 0;
    bit tgl_known = 0;
    bit tgl_exp   = 0;

    always #2.5 clk = !clk;

    ewr_status_mux #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .wr_n(wr_n),
        .busy(busy), .last_wr_byte(last_wr_byte), .arr_rdata(arr_rdata),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic bit read_on(bit c, bit o, bit w);
        return !c && !o && w;
    endfunction

    function automatic logic [W-1:0] status_of(logic [W-1:0] lw, bit t);
        logic [W-1:0] s;
        s = '0;
        s[W-1] = !lw[W-1];
        s[W-2] = t;
        return s;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one set of inputs, let one edge pass, compare outputs.
    task automatic step(bit c, bit o, bit w, bit b, logic [W-1:0] lw, logic [W-1:0] ar);
        bit rd;
        bit rise;
        @(negedge clk);
        cs_n = c; oe_n = o; wr_n = w; busy = b;
        last_wr_byte = lw; arr_rdata = ar;
        rd   = read_on(c, o, w);
        rise = rd && !prev_rd;
        prev_rd = rd;
        @(posedge clk);
        #1;
        if (!rd) begin
            check(w ? "R1 released" : "R8 strobe releases", {7'b0, dq_oe}, 8'h00);
            check("R1 bus zero", dq_out, '0);
        end else if (!b) begin
            check("R4 oe", {7'b0, dq_oe}, 8'h01);
            check("R4 array data", dq_out, ar);
        end else begin
            check("R2 oe", {7'b0, dq_oe}, 8'h01);
            if (rise) begin
                if (tgl_known) tgl_exp = !tgl_exp;
                else begin tgl_exp = dq_out[W-2]; tgl_known = 1; end
            end
            if (tgl_known) check(rise ? "R3 toggle flip" : "R6 toggle hold",
                                 status_of(lw, tgl_exp), dq_out);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // Reset state
        #1;
        check("R1 reset oe", {7'b0, dq_oe}, 8'h00);
        check("R1 reset bus", dq_out, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed: idle read, then busy polls via oe only
        step(0, 0, 1, 0, 8'h80, 8'h3C);   // R4
        step(1, 1, 1, 0, 8'h80, 8'h3C);
        step(0, 0, 1, 1, 8'h80, 8'h3C);   // R2 first poll, learn toggle
        step(0, 0, 1, 1, 8'h80, 8'h3C);   // R6 held read keeps toggle
        step(0, 1, 1, 1, 8'h80, 8'h3C);   // release by oe
        step(0, 0, 1, 1, 8'h80, 8'h3C);   // R3 via oe
        step(1, 0, 1, 1, 8'h80, 8'h3C);   // release by cs
        step(0, 0, 1, 1, 8'h80, 8'h3C);   // R3 via cs
        step(0, 0, 0, 1, 8'h80, 8'h3C);   // R8 strobe low
        step(0, 0, 1, 1, 8'h80, 8'h3C);   // R3 after strobe
        // R7: held read across busy falling, then rising
        step(0, 0, 1, 0, 8'h80, 8'hA5);   // R7 array at next edge
        step(0, 0, 1, 1, 8'h80, 8'hA5);   // R7 status, no toggle (R6 check)
        step(1, 1, 1, 0, 8'h00, 8'hA5);
        // R6: new write cycle, toggle carried over
        step(0, 0, 1, 1, 8'h00, 8'h11);   // R3 across write cycles, R2 bit7=1

        // Random mix
        for (int i = 0; i < 600; i++) begin
            automatic bit c = ($urandom_range(0, 3) == 0);
            automatic bit o = ($urandom_range(0, 3) == 0);
            automatic bit w = ($urandom_range(0, 7) != 0);
            automatic bit b = ($urandom_range(0, 2) != 0);
            step(c, o, w, b, W'($urandom), W'($urandom));
        end
        summary();
    end
endmodule